// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This unit sits beside a five-stage in-order pipeline that has no forwarding paths. Each cycle it compares the two register indices that decode is about to read against the destinations of every instruction still in flight. Those in-flight instructions are decode's own current output and the instructions in execute, load/store and write-back. If any of them will write a register that decode needs, the unit raises a stall request to decode straight away. Decode clears its own outputs while it is stalled. A match against decode's own output therefore disappears on the next cycle, and the stall cannot lock up.

When execute sends a branch request to fetch, the unit loads a small counter on the following clock edge. It holds a drop request to execute high for two cycles. This flushes the wrong-path instructions in the fetch and decode outputs. A branch request that arrives during a drop reloads the counter.

Top module: `hazard_unit`

## Requirements
- R1: `stall_o` is high when `src1_idx_i` equals the non-zero destination of any active writer. Writer slot 0 is the decode output, slot 1 is execute, slot 2 is load/store and slot 3 is write-back. Slot k occupies bits [5k+4:5k] of `wr_idx_i` and bit k of `wr_en_i` and `wr_vld_i`.
- R2: `stall_o` is high when `src2_idx_i` equals the non-zero destination of any active writer.
- R3: A writer is active only when both its `wr_en_i` bit and its `wr_vld_i` bit are high. An inactive writer never causes a stall.
- R4: A destination index of 0 never causes a stall, even when a source index is also 0.
- R5: `stall_o` follows its inputs within the same cycle. It does not wait for a clock edge.
- R6: `drop_o` goes high on the first rising edge of `clk_i` at which `br_req_i` is sampled high.
- R7: After a branch request that is not followed by another, `drop_o` stays high for exactly two cycles and then goes low.
- R8: A branch request sampled while `drop_o` is high restarts the two-cycle hold.
- R9: While `rst_ni` is low, both outputs are low and the drop counter is cleared, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src1_idx_i | input | 5 | First register index decode will read |
| src2_idx_i | input | 5 | Second register index decode will read |
| wr_idx_i | input | 20 | Destination index of each writer slot, 5 bits per slot |
| wr_en_i | input | 4 | Write enable of each writer slot |
| wr_vld_i | input | 4 | Valid flag of each writer slot |
| br_req_i | input | 1 | Branch request from execute to fetch |
| stall_o | output | 1 | Stall request to decode |
| drop_o | output | 1 | Drop request to execute |

## Verification
The stall result is combinational. The bench applies each vector at a falling edge and samples `stall_o` 1 ns later, before any rising edge occurs. The drop result passes through one register. A branch request driven at a falling edge is therefore due after the next rising edge, and the bench samples `drop_o` at each following falling edge. It expects high on the first two of those edges and low on the third. In the restart case, the two-edge window is counted again from the last request.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned REG_IDX_W   = 5;
  localparam int unsigned NUM_WRITERS = 4;
  localparam int unsigned NUM_SRCS    = 2;
  localparam int unsigned DROP_CYCLES = 2;

  // writer slot order: decode output, execute, load/store, write-back
  typedef enum logic [1:0] {
    WR_DEC = 2'd0,
    WR_EXE = 2'd1,
    WR_LSU = 2'd2,
    WR_WB  = 2'd3
  } writer_slot_e;
endpackage

// File: rtl/hazard_src_match.sv
module hazard_src_match #(
  parameter int unsigned REG_IDX_W   = 5,
  parameter int unsigned NUM_WRITERS = 4
) (
  input  logic [REG_IDX_W-1:0]                  src_i,
  input  logic [NUM_WRITERS-1:0][REG_IDX_W-1:0] wr_idx_i,
  input  logic [NUM_WRITERS-1:0]                wr_act_i,
  output logic                                  hit_o
);
  logic [NUM_WRITERS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_WRITERS; k++) begin : g_cmp
    // index 0 is hardwired, never a real write
    assign hit_vec[k] = wr_act_i[k] && (wr_idx_i[k] != '0) && (wr_idx_i[k] == src_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/hazard_drop_ctrl.sv
module hazard_drop_ctrl #(
  parameter int unsigned DROP_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic br_req_i,
  output logic drop_o
);
  localparam int unsigned CNT_W = $clog2(DROP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DROP_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (br_req_i)        cnt_q <= CNT_LOAD;   // reload also restarts an active drop
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign drop_o = (cnt_q != '0);

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_req_i |=> (cnt_q == CNT_LOAD) && drop_o);

  p_count_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_req_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_idle_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_req_i && !drop_o) |=> !drop_o);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int unsigned IDX_W    = REG_IDX_W,
  parameter int unsigned N_WR     = NUM_WRITERS,
  parameter int unsigned DROP_LEN = DROP_CYCLES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            src1_idx_i,
  input  logic [IDX_W-1:0]            src2_idx_i,
  input  logic [N_WR-1:0][IDX_W-1:0]  wr_idx_i,
  input  logic [N_WR-1:0]             wr_en_i,
  input  logic [N_WR-1:0]             wr_vld_i,
  input  logic                        br_req_i,
  output logic                        stall_o,
  output logic                        drop_o
);
  logic [N_WR-1:0]               wr_act;
  logic [NUM_SRCS-1:0][IDX_W-1:0] src_idx;
  logic [NUM_SRCS-1:0]           src_hit;

  assign wr_act     = wr_en_i & wr_vld_i;
  assign src_idx[0] = src1_idx_i;
  assign src_idx[1] = src2_idx_i;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    hazard_src_match #(
      .REG_IDX_W   (IDX_W),
      .NUM_WRITERS (N_WR)
    ) u_match (
      .src_i    (src_idx[s]),
      .wr_idx_i (wr_idx_i),
      .wr_act_i (wr_act),
      .hit_o    (src_hit[s])
    );
  end

  assign stall_o = rst_ni && (|src_hit);

  hazard_drop_ctrl #(
    .DROP_CYCLES (DROP_LEN)
  ) u_drop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .br_req_i (br_req_i),
    .drop_o   (drop_o)
  );

  p_inactive_no_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_act == '0) |-> !stall_o);

  p_zero_dest_no_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_idx_i == '0) |-> !stall_o);

  p_drop_after_branch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_req_i |=> drop_o);

  always_comb begin
    if (!rst_ni) p_reset_quiet_r9: assert (!stall_o);
  end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [19:0] idx;   // {wb, lsu, exe, dec}
    logic [3:0]  en;
    logic [3:0]  vld;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'd1,  5'd2,  {5'd0, 5'd0, 5'd0, 5'd0},   4'hf, 4'hf, 1'b0},
    '{5'd5,  5'd8,  {5'd0, 5'd0, 5'd0, 5'd5},   4'hf, 4'hf, 1'b1},
    '{5'd5,  5'd8,  {5'd0, 5'd0, 5'd5, 5'd0},   4'hf, 4'hf, 1'b1},
    '{5'd3,  5'd7,  {5'd0, 5'd7, 5'd0, 5'd0},   4'hf, 4'hf, 1'b1},
    '{5'd3,  5'd7,  {5'd7, 5'd0, 5'd0, 5'd0},   4'hf, 4'hf, 1'b1},
    '{5'd9,  5'd1,  {5'd0, 5'd0, 5'd9, 5'd0},   4'hd, 4'hf, 1'b0},
    '{5'd9,  5'd1,  {5'd0, 5'd0, 5'd9, 5'd0},   4'hf, 4'hd, 1'b0},
    '{5'd0,  5'd0,  {5'd0, 5'd0, 5'd0, 5'd0},   4'hf, 4'hf, 1'b0},
    '{5'd3,  5'd4,  {5'd6, 5'd5, 5'd2, 5'd1},   4'hf, 4'hf, 1'b0},
    '{5'd31, 5'd4,  {5'd31, 5'd0, 5'd0, 5'd0},  4'hf, 4'hf, 1'b1},
    '{5'd1,  5'd12, {5'd12, 5'd12, 5'd12, 5'd12}, 4'hf, 4'h1, 1'b1},
    '{5'd11, 5'd12, {5'd12, 5'd11, 5'd12, 5'd11}, 4'h0, 4'hf, 1'b0}
  };
  localparam string VREQ [NV] = '{"R4", "R1", "R1", "R2", "R2", "R3",
                                  "R3", "R4", "R1", "R1", "R2", "R3"};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  src1 = '0, src2 = '0;
  logic [3:0][4:0] wr_idx = '0;
  logic [3:0]  wr_en = '0, wr_vld = '0;
  logic        br = 1'b0;
  logic        stall, drop;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .src1_idx_i(src1), .src2_idx_i(src2),
    .wr_idx_i(wr_idx), .wr_en_i(wr_en), .wr_vld_i(wr_vld), .br_req_i(br),
    .stall_o(stall), .drop_o(drop)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    src1 = v.rs1; src2 = v.rs2; wr_idx = v.idx; wr_en = v.en; wr_vld = v.vld;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs low despite a match and a branch
    apply(VEC[1]); br = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "stall in reset", stall, 1'b0);
    chk("R9", "drop in reset", drop, 1'b0);
    br = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    apply(VEC[0]); #1;
    chk("R9", "drop after reset", drop, 1'b0);

    // table of stall vectors: result is combinational (R5)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      #1;
      chk(VREQ[i], $sformatf("stall vector %0d", i), stall, VEC[i].exp);
    end

    // R5: mid-cycle change seen without an edge
    @(negedge clk);
    apply(VEC[0]); #1;
    chk("R5", "stall idle", stall, 1'b0);
    wr_idx[2] = 5'd2; #1;
    chk("R5", "stall same cycle", stall, 1'b1);
    apply(VEC[0]);

    // R6/R7: single branch request
    @(negedge clk); br = 1'b1; #1;
    chk("R6", "drop before edge", drop, 1'b0);
    @(negedge clk); br = 1'b0;
    chk("R6", "drop after edge", drop, 1'b1);
    @(negedge clk);
    chk("R7", "drop second cycle", drop, 1'b1);
    @(negedge clk);
    chk("R7", "drop released", drop, 1'b0);
    @(negedge clk);
    chk("R7", "drop stays low", drop, 1'b0);

    // R8: request during drop restarts the hold
    br = 1'b1;
    @(negedge clk); br = 1'b0;
    chk("R8", "drop first", drop, 1'b1);
    br = 1'b1;
    @(negedge clk); br = 1'b0;
    chk("R8", "drop reloaded", drop, 1'b1);
    @(negedge clk);
    chk("R8", "drop extended", drop, 1'b1);
    @(negedge clk);
    chk("R8", "drop end after restart", drop, 1'b0);

    // R9: asynchronous reset mid-drop
    br = 1'b1;
    @(negedge clk); br = 1'b0;
    chk("R9", "drop before reset", drop, 1'b1);
    rst_ni = 1'b0; #1;
    chk("R9", "drop cleared by reset", drop, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R9", "counter cleared", drop, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule